// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sits between the pins of a synchronous burst memory and its access logic. It decides when the device is in a data-retaining low-power state. A single sleep request input drives it. The board ties that input low when it is not used. The clock keeps running the whole time, and the block measures both the entry delay and the recovery delay by counting clock edges.

While the device is asleep, the block blocks every other control input. The address strobes and the general control lines reach the access logic as zero. The data drivers are turned off and the data outputs are held at zero. The stored contents are assumed to be retained.

After recovery, a lockout window follows. During that window the general controls pass through again, but the address strobes stay blocked, so no new cycle can start. The block reports two flags to the cycle controller: an asleep flag and an access-allowed flag. The ordinary deselected case needs no help from this block: when the device is awake and out of lockout, every input passes through.

Top module: `snooze_seq`

## Requirements
- R1: After reset the block is awake with access allowed: `asleep` is 0 and `access_ok` is 1.
- R2: `asleep` becomes 1 in the cycle after the ENTRY_CYC-th consecutive rising clock edge at which `sleep_req` is sampled high.
- R3: If `sleep_req` is sampled low before ENTRY_CYC consecutive high samples have been seen, `asleep` stays 0. A later request then needs a fresh run of ENTRY_CYC high samples. A run of ENTRY_CYC-1 high samples is not enough.
- R4: While `asleep` is 1, `stb_out` and `ctl_out` are all zero and `access_ok` is 0, whatever `stb_in` and `ctl_in` carry.
- R5: While `asleep` is 1, `dq_oe` is 0 and `dq_o` is all zero. Otherwise `dq_oe` equals `rd_en`, and `dq_o` equals `rd_data` when `dq_oe` is 1 and is zero when `dq_oe` is 0.
- R6: `asleep` returns to 0 in the cycle after the EXIT_CYC-th consecutive edge at which `sleep_req` is sampled low. A high sample during recovery keeps the block asleep, and the low run must then start again from zero.
- R7: For the LOCK_CYC cycles after `asleep` falls, `access_ok` is 0 and `stb_out` is zero, while `ctl_out` follows `ctl_in`. `sleep_req` is ignored during this window. A new entry count can start only once the window has ended.
- R8: When the block is awake and out of lockout, including while an entry count is running, `stb_out` follows `stb_in`, `ctl_out` follows `ctl_in`, and `access_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, running in every state |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Low-power request, active high |
| stb_in | input | STB_W | Address strobes from the pins, active high |
| ctl_in | input | CTL_W | Other control inputs from the pins |
| rd_en | input | 1 | Read path asks to drive the data bus |
| rd_data | input | DW | Read data from the array |
| stb_out | output | STB_W | Gated address strobes to the cycle controller |
| ctl_out | output | CTL_W | Gated control inputs to the access logic |
| dq_oe | output | 1 | Data driver enable |
| dq_o | output | DW | Data out, zero when not driven |
| asleep | output | 1 | Low-power state flag |
| access_ok | output | 1 | New strobe-initiated cycles are permitted |

## Verification
The bench aims at the edges of the counts:
- A request held one cycle short of the entry delay must not put the device to sleep. A design with an off-by-one count would go to sleep there.
- A short request that is dropped must clear the count. A design that keeps a partial count would fall asleep early on the next request.
- A single high sample in the middle of recovery must restart the wake count. A design that does not restart it would wake too soon.
- A sleep request raised during lockout must neither shorten the window nor reopen the strobes. A design that reacts to it would admit a strobe inside the window or extend the window.
- The data bus is watched while `rd_en` is held high in sleep. Any drive there would show up as a nonzero enable or nonzero data.

// File: rtl/snooze_seq.sv
module snooze_seq #(
  parameter int ENTRY_CYC = 8,
  parameter int EXIT_CYC  = 8,
  parameter int LOCK_CYC  = 8,
  parameter int STB_W     = 2,
  parameter int CTL_W     = 6,
  parameter int DW        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [STB_W-1:0] stb_in,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic             rd_en,
  input  logic [DW-1:0]    rd_data,
  output logic [STB_W-1:0] stb_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             dq_oe,
  output logic [DW-1:0]    dq_o,
  output logic             asleep,
  output logic             access_ok
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ?
                        ((ENTRY_CYC > LOCK_CYC) ? ENTRY_CYC : LOCK_CYC) :
                        ((EXIT_CYC > LOCK_CYC) ? EXIT_CYC : LOCK_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYC);

  typedef enum logic [2:0] {S_RUN, S_DOZE, S_SLEEP, S_WAKE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (sleep_req) begin
            st  <= S_DOZE;
            cnt <= CW'(1);
          end
        S_DOZE:
          if (!sleep_req)             st <= S_RUN;
          else if (cnt == ENTRY_LAST) st <= S_SLEEP;
          else                        cnt <= cnt + 1'b1;
        S_SLEEP:
          if (!sleep_req) begin
            st  <= S_WAKE;
            cnt <= CW'(1);
          end
        S_WAKE:
          if (sleep_req) st <= S_SLEEP;
          else if (cnt == EXIT_LAST) begin
            st  <= S_HOLD;
            cnt <= CW'(1);
          end else cnt <= cnt + 1'b1;
        S_HOLD:
          if (cnt == LOCK_LAST) st <= S_RUN;
          else                  cnt <= cnt + 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  assign asleep    = (st == S_SLEEP) || (st == S_WAKE);
  assign access_ok = (st == S_RUN) || (st == S_DOZE);
  assign stb_out   = access_ok ? stb_in : '0;
  assign ctl_out   = asleep ? '0 : ctl_in;
  assign dq_oe     = rd_en && !asleep;
  assign dq_o      = dq_oe ? rd_data : '0;
endmodule

module snooze_seq_chk #(
  parameter int ENTRY_CYC = 8,
  parameter int EXIT_CYC  = 8,
  parameter int LOCK_CYC  = 8,
  parameter int DW        = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req,
  input logic          asleep,
  input logic          access_ok,
  input logic          dq_oe,
  input logic [DW-1:0] dq_o
);
  localparam int HW = $clog2(ENTRY_CYC + 1);
  localparam int LW = $clog2(EXIT_CYC + 1);
  localparam int KW = $clog2(LOCK_CYC + 1);

  logic [HW-1:0] hi_run;
  logic [LW-1:0] lo_run;
  logic [KW-1:0] since_wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run     <= '0;
      lo_run     <= '0;
      since_wake <= KW'(LOCK_CYC);
    end else begin
      hi_run <= !sleep_req ? '0 : (hi_run == HW'(ENTRY_CYC)) ? hi_run : hi_run + 1'b1;
      lo_run <= sleep_req ? '0 : (lo_run == LW'(EXIT_CYC)) ? lo_run : lo_run + 1'b1;
      if (asleep) since_wake <= '0;
      else if (since_wake != KW'(LOCK_CYC)) since_wake <= since_wake + 1'b1;
    end
  end

  // R2
  entry_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> hi_run == HW'(ENTRY_CYC));

  // R6
  exit_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> lo_run == LW'(EXIT_CYC));

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && since_wake != KW'(LOCK_CYC)) |-> !access_ok);

  // R4
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !access_ok);

  // R5
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!dq_oe && dq_o == '0));
endmodule

bind snooze_seq snooze_seq_chk #(
  .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .LOCK_CYC(LOCK_CYC), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .asleep(asleep),
  .access_ok(access_ok), .dq_oe(dq_oe), .dq_o(dq_o)
);

// File: tb/sim_snooze_seq.sv
`timescale 1ns/1ps
module sim_snooze_seq;
  localparam int ENTRY_CYC = 8, EXIT_CYC = 8, LOCK_CYC = 8;
  localparam int STB_W = 2, CTL_W = 6, DW = 32;
  localparam int EW = 2 + STB_W + CTL_W + 1 + DW;

  logic clk = 0, rst_n = 0, sleep_req = 0, rd_en = 0;
  logic [STB_W-1:0] stb_in = '0;
  logic [CTL_W-1:0] ctl_in = '0;
  logic [DW-1:0] rd_data = '0;
  logic [STB_W-1:0] stb_out;
  logic [CTL_W-1:0] ctl_out;
  logic dq_oe, asleep, access_ok;
  logic [DW-1:0] dq_o;

  int checks = 0, errors = 0;
  int ph = 0, cnt = 0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  snooze_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .LOCK_CYC(LOCK_CYC),
               .STB_W(STB_W), .CTL_W(CTL_W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stb_in(stb_in),
    .ctl_in(ctl_in), .rd_en(rd_en), .rd_data(rd_data), .stb_out(stb_out),
    .ctl_out(ctl_out), .dq_oe(dq_oe), .dq_o(dq_o), .asleep(asleep),
    .access_ok(access_ok));

  // ph: 0 awake, 1 counting toward sleep, 2 asleep, 3 recovering, 4 lockout
  task automatic step(input logic s, input int seed, input logic rd, input string tag);
    logic slp, acc, oe;
    logic [STB_W-1:0] es;
    logic [CTL_W-1:0] ec;
    logic [DW-1:0] ed;
    @(negedge clk);
    sleep_req = s;
    stb_in  = STB_W'(seed * 3 + 1);
    ctl_in  = CTL_W'(seed * 37 + 5);
    rd_en   = rd;
    rd_data = DW'(32'hA5000000 + seed * 32'h1111);
    slp = (ph == 2) || (ph == 3);
    acc = (ph == 0) || (ph == 1);
    oe  = rd && !slp;
    es  = acc ? stb_in : '0;
    ec  = slp ? '0 : ctl_in;
    ed  = oe ? rd_data : '0;
    exp_q.push_back({slp, acc, es, ec, oe, ed});
    tag_q.push_back(tag);
    @(posedge clk);
    case (ph)
      0: if (s) begin ph = 1; cnt = 1; end
      1: if (!s) ph = 0; else if (cnt == ENTRY_CYC) ph = 2; else cnt++;
      2: if (!s) begin ph = 3; cnt = 1; end
      3: if (s) ph = 2; else if (cnt == EXIT_CYC) begin ph = 4; cnt = 1; end else cnt++;
      4: if (cnt == LOCK_CYC) ph = 0; else cnt++;
      default: ph = 0;
    endcase
    // counts above are edges seen so far, so compare once they reach the full run
    if (ph == 1 && cnt == ENTRY_CYC) ph = 2;
    if (ph == 3 && cnt == EXIT_CYC) begin ph = 4; cnt = 0; end
    if (ph == 4 && cnt == LOCK_CYC) ph = 0;
  endtask

  initial begin : monitor
    logic [EW-1:0] e, a;
    string t;
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {asleep, access_ok, stb_out, ctl_out, dq_oe, dq_o};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (asleep !== 1'b0 || access_ok !== 1'b1) begin
      errors++;
      $display("FAIL R1 actual=%b%b expected=01", asleep, access_ok);
    end
    for (int i = 0; i < 8; i++) step(0, i, i[0], "R8");
    for (int i = 0; i < 5; i++) step(1, 20 + i, 1, "R3");
    for (int i = 0; i < 3; i++) step(0, 30 + i, 0, "R3");
    for (int i = 0; i < ENTRY_CYC - 1; i++) step(1, 40 + i, 1, "R3");
    for (int i = 0; i < 2; i++) step(0, 50 + i, 1, "R3");
    for (int i = 0; i < ENTRY_CYC; i++) step(1, 60 + i, i[0], "R2");
    for (int i = 0; i < 6; i++) step(1, 70 + i, 1, "R4");
    for (int i = 0; i < 4; i++) step(1, 80 + i, 1, "R5");
    for (int i = 0; i < 3; i++) step(0, 90 + i, 1, "R6");
    step(1, 95, 1, "R6");
    for (int i = 0; i < EXIT_CYC; i++) step(0, 100 + i, 1, "R6");
    for (int i = 0; i < 4; i++) step(1, 110 + i, 1, "R7");
    for (int i = 0; i < LOCK_CYC; i++) step(0, 120 + i, i[0], "R7");
    for (int i = 0; i < 6; i++) step(0, 130 + i, i[0], "R8");
    @(negedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule